// File: doc/BRIEF.md
# Internal Stack Pointer Unit

This block holds the stack pointer of a small 8-bit controller. It turns push and pop requests into accesses to an on-chip 8-bit-addressed RAM. The pointer always names the byte that was written last. A push first advances the pointer and then writes at the new address. A pop first reads at the current address and then steps the pointer back. Arithmetic on the pointer wraps modulo 256 and raises no error.

A two-beat push stores a 16-bit word for call-type operations, low byte first. A two-beat pop returns a word for return-type operations and delivers the high byte first. A direct load overrides the pointer.

The unit contains the stack RAM, written so that it maps onto block RAM. The RAM address, write strobe, write data and read strobe are all registered and brought out. Popped bytes come back from the RAM with a valid flag.

Top module: `stack_ptr_unit`

## Requirements
- R1: When a synchronous reset is applied, `sp` becomes 07h and `busy`, `ram_we`, `ram_re` and `pop_valid` are all 0 in the cycle that follows.
- R2: A single push accepted on a clock edge leaves `sp` = old `sp` + 1 after that edge. For that one cycle it also drives `ram_we` = 1, `ram_addr` = the new `sp` and `ram_wdata` = `push_data`. `ram_we` and `ram_re` are never high together.
- R3: A single pop accepted on a clock edge leaves `sp` = old `sp` - 1 after that edge. For that one cycle it also drives `ram_re` = 1 with `ram_addr` = the old `sp`. The byte read appears on `pop_data` with `pop_valid` = 1 one cycle after `ram_re`.
- R4: Stack contents behave last-in first-out: a pop returns the byte most recently pushed to that address.
- R5: A two-byte push writes `call_push_data[7:0]` at old `sp` + 1 in the first cycle and `call_push_data[15:0]`'s upper byte at old `sp` + 2 in the next cycle. `busy` is 1 for exactly that second cycle, and `sp` ends at old `sp` + 2.
- R6: A two-byte pop reads at old `sp` first and at old `sp` - 1 in the next cycle, so the high byte is returned before the low byte. `busy` is 1 for the second cycle, and `sp` ends at old `sp` - 2.
- R7: `sp` wraps modulo 256: a push at FFh writes address 00h, and a pop at 00h leaves FFh.
- R8: `sp_load` writes `sp_load_data` into `sp`, overriding any simultaneous request. If it arrives in the second cycle of a two-byte operation, that cycle's access is dropped and no strobe is raised.
- R9: Push and pop requests presented while `busy` is 1 are ignored.
- R10: Among simultaneous requests the order is: two-byte push, then single push, then two-byte pop, then single pop. Only the winner is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| call_push_req | input | 1 | Push a 16-bit word, low byte first |
| call_push_data | input | 16 | Word to push |
| pop_req | input | 1 | Pop one byte |
| ret_pop_req | input | 1 | Pop a 16-bit word, high byte first |
| sp_load | input | 1 | Load the pointer directly |
| sp_load_data | input | 8 | Value loaded into the pointer |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Second beat of a two-byte operation in progress |
| ram_addr | output | 8 | Registered stack RAM address |
| ram_we | output | 1 | Registered RAM write strobe |
| ram_wdata | output | 8 | Registered RAM write data |
| ram_re | output | 1 | Registered RAM read strobe |
| pop_data | output | 8 | Byte returned by a pop |
| pop_valid | output | 1 | `pop_data` is valid this cycle |

## Verification
A wrong pointer shows up on `sp` one cycle after the faulty edge. It also shows up on `ram_addr` at the next push or pop. Because the pointer is exposed and every strobe is registered, a bad increment, decrement or wrap is seen within a single cycle of its cause. A wrong beat order or a lost second beat in a two-byte operation corrupts stack contents. That shows up later, at `pop_data`, two cycles after the pop that reads the damaged address.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_HI = 2'd1,
    ST_POP_LO  = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stkp_ram.sv
module stkp_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage and read port without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/stkp_ctrl.sv
module stkp_ctrl
  import stkp_pkg::*;
#(
  parameter int              AW       = 8,
  parameter int              DW       = 8,
  parameter logic [AW-1:0]   RESET_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_req,
  input  logic [DW-1:0]   push_data,
  input  logic            call_push_req,
  input  logic [2*DW-1:0] call_push_data,
  input  logic            pop_req,
  input  logic            ret_pop_req,
  input  logic            sp_load,
  input  logic [AW-1:0]   sp_load_data,
  output logic [AW-1:0]   sp,
  output logic            busy,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_re
);
  localparam logic [AW-1:0] STEP = AW'(1);

  stk_state_e    state;
  logic [DW-1:0] hold_hi;
  logic [AW-1:0] sp_up, sp_dn;

  assign sp_up = sp + STEP;
  assign sp_dn = sp - STEP;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= RESET_SP;
      state     <= ST_IDLE;
      hold_hi   <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      ram_re    <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      if (sp_load) begin
        sp    <= sp_load_data;
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (call_push_req) begin
              sp        <= sp_up;
              ram_addr  <= sp_up;
              ram_we    <= 1'b1;
              ram_wdata <= call_push_data[DW-1:0];
              hold_hi   <= call_push_data[2*DW-1:DW];
              state     <= ST_PUSH_HI;
            end else if (push_req) begin
              sp        <= sp_up;
              ram_addr  <= sp_up;
              ram_we    <= 1'b1;
              ram_wdata <= push_data;
            end else if (ret_pop_req) begin
              ram_addr <= sp;
              ram_re   <= 1'b1;
              sp       <= sp_dn;
              state    <= ST_POP_LO;
            end else if (pop_req) begin
              ram_addr <= sp;
              ram_re   <= 1'b1;
              sp       <= sp_dn;
            end
          end
          ST_PUSH_HI: begin
            sp        <= sp_up;
            ram_addr  <= sp_up;
            ram_we    <= 1'b1;
            ram_wdata <= hold_hi;
            state     <= ST_IDLE;
          end
          ST_POP_LO: begin
            ram_addr <= sp;
            ram_re   <= 1'b1;
            sp       <= sp_dn;
            state    <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] RESET_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_req,
  input  logic [DW-1:0]   push_data,
  input  logic            call_push_req,
  input  logic [2*DW-1:0] call_push_data,
  input  logic            pop_req,
  input  logic            ret_pop_req,
  input  logic            sp_load,
  input  logic [AW-1:0]   sp_load_data,
  output logic [AW-1:0]   sp,
  output logic            busy,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_re,
  output logic [DW-1:0]   pop_data,
  output logic            pop_valid
);
  stkp_ctrl #(.AW(AW), .DW(DW), .RESET_SP(RESET_SP)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .push_req       (push_req),
    .push_data      (push_data),
    .call_push_req  (call_push_req),
    .call_push_data (call_push_data),
    .pop_req        (pop_req),
    .ret_pop_req    (ret_pop_req),
    .sp_load        (sp_load),
    .sp_load_data   (sp_load_data),
    .sp             (sp),
    .busy           (busy),
    .ram_addr       (ram_addr),
    .ram_we         (ram_we),
    .ram_wdata      (ram_wdata),
    .ram_re         (ram_re)
  );

  stkp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (ram_we),
    .re     (ram_re),
    .addr   (ram_addr),
    .wdata  (ram_wdata),
    .rdata  (pop_data),
    .rvalid (pop_valid)
  );
endmodule

// File: rtl/stkp_chk.sv
module stkp_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            push_req,
  input logic [DW-1:0]   push_data,
  input logic            call_push_req,
  input logic [2*DW-1:0] call_push_data,
  input logic            pop_req,
  input logic            ret_pop_req,
  input logic            sp_load,
  input logic [AW-1:0]   sp_load_data,
  input logic [AW-1:0]   sp,
  input logic            busy,
  input logic [AW-1:0]   ram_addr,
  input logic            ram_we,
  input logic [DW-1:0]   ram_wdata,
  input logic            ram_re,
  input logic            pop_valid
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic idle_go;
  assign idle_go = !busy && !sp_load;

  p_push_r2: assert property (@(posedge clk) disable iff (rst)
    idle_go && push_req && !call_push_req |=>
      ram_we && sp == $past(sp) + STEP && ram_addr == sp && ram_wdata == $past(push_data));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  p_pop_r3: assert property (@(posedge clk) disable iff (rst)
    idle_go && pop_req && !call_push_req && !push_req && !ret_pop_req |=>
      ram_re && ram_addr == $past(sp) && sp == $past(sp) - STEP);

  p_read_lat_r3: assert property (@(posedge clk) disable iff (rst)
    ram_re |=> pop_valid);

  p_call_first_r5: assert property (@(posedge clk) disable iff (rst)
    idle_go && call_push_req |=>
      busy && ram_we && ram_wdata == $past(call_push_data[DW-1:0]));

  p_busy_once_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> sp == $past(sp_load_data) && !ram_we && !ram_re && !busy);
endmodule

bind stack_ptr_unit stkp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .push_req       (push_req),
  .push_data      (push_data),
  .call_push_req  (call_push_req),
  .call_push_data (call_push_data),
  .pop_req        (pop_req),
  .ret_pop_req    (ret_pop_req),
  .sp_load        (sp_load),
  .sp_load_data   (sp_load_data),
  .sp             (sp),
  .busy           (busy),
  .ram_addr       (ram_addr),
  .ram_we         (ram_we),
  .ram_wdata      (ram_wdata),
  .ram_re         (ram_re),
  .pop_valid      (pop_valid)
);

// File: tb/stack_ptr_unit_tb.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0, call_push_req = 1'b0, pop_req = 1'b0, ret_pop_req = 1'b0, sp_load = 1'b0;
  logic [7:0]  push_data = '0, sp_load_data = '0;
  logic [15:0] call_push_data = '0;
  logic [7:0]  sp, ram_addr, ram_wdata, pop_data;
  logic        busy, ram_we, ram_re, pop_valid;

  always #4 clk = ~clk;  // 125 MHz

  stack_ptr_unit u_dut (
    .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
    .call_push_req(call_push_req), .call_push_data(call_push_data),
    .pop_req(pop_req), .ret_pop_req(ret_pop_req), .sp_load(sp_load),
    .sp_load_data(sp_load_data), .sp(sp), .busy(busy), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
    .pop_data(pop_data), .pop_valid(pop_valid)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 second push beat, 2 second pop beat
  int m_sp, m_st, m_hold, m_addr, m_wd, m_pd;
  bit m_we, m_re, m_pv, m_known;
  int mem [256];
  bit mval [256];

  always @(posedge clk) begin
    if (rst) begin
      m_sp = 7; m_st = 0; m_we = 0; m_re = 0; m_pv = 0;
    end else begin
      m_pv = m_re;
      if (m_re) begin m_pd = mem[m_addr]; m_known = mval[m_addr]; end
      if (m_we) begin mem[m_addr] = m_wd; mval[m_addr] = 1; end
      m_we = 0; m_re = 0;
      if (sp_load) begin
        m_sp = sp_load_data; m_st = 0;
      end else if (m_st == 1) begin
        m_sp = (m_sp + 1) % 256; m_addr = m_sp; m_we = 1; m_wd = m_hold; m_st = 0;
      end else if (m_st == 2) begin
        m_addr = m_sp; m_re = 1; m_sp = (m_sp + 255) % 256; m_st = 0;
      end else if (call_push_req) begin
        m_sp = (m_sp + 1) % 256; m_addr = m_sp; m_we = 1;
        m_wd = call_push_data[7:0]; m_hold = call_push_data[15:8]; m_st = 1;
      end else if (push_req) begin
        m_sp = (m_sp + 1) % 256; m_addr = m_sp; m_we = 1; m_wd = push_data;
      end else if (ret_pop_req) begin
        m_addr = m_sp; m_re = 1; m_sp = (m_sp + 255) % 256; m_st = 2;
      end else if (pop_req) begin
        m_addr = m_sp; m_re = 1; m_sp = (m_sp + 255) % 256;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk("sp", sp, m_sp);
      chk("busy", busy, (m_st != 0) ? 1 : 0);
      chk("ram_we", ram_we, m_we);
      chk("ram_re", ram_re, m_re);
      if (m_we) begin chk("ram_addr", ram_addr, m_addr); chk("ram_wdata", ram_wdata, m_wd); end
      if (m_re) chk("ram_addr", ram_addr, m_addr);
      chk("pop_valid", pop_valid, m_pv);
      if (m_pv && m_known) chk("pop_data", pop_data, m_pd);
    end
  endtask

  task automatic clr();
    push_req = 0; call_push_req = 0; pop_req = 0; ret_pop_req = 0; sp_load = 0;
  endtask

  task automatic push(input logic [7:0] d);
    push_req = 1; push_data = d; tick(); clr();
  endtask

  task automatic pop();
    pop_req = 1; tick(); clr();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk("reset sp", sp, 8'h07);
    chk("reset strobes", {busy, ram_we, ram_re, pop_valid}, 0);

    tag = "R2";
    push(8'hA1); push(8'hB2); push(8'hC3);
    tag = "R4";
    pop(); pop(); pop(); tick(); tick();

    tag = "R5";
    call_push_data = 16'hBEEF; call_push_req = 1; tick(); clr(); tick(); tick();
    tag = "R6";
    ret_pop_req = 1; tick(); clr(); tick(); tick(); tick();

    tag = "R7";
    sp_load = 1; sp_load_data = 8'hFE; tick(); clr();
    push(8'h11); push(8'h22); push(8'h33);
    pop(); pop(); pop(); pop(); tick(); tick();
    sp_load = 1; sp_load_data = 8'h00; tick(); clr(); pop(); tick(); tick();

    tag = "R8";
    sp_load = 1; sp_load_data = 8'h40; push_req = 1; push_data = 8'h55; tick(); clr();
    call_push_data = 16'h1234; call_push_req = 1; tick(); clr();
    sp_load = 1; sp_load_data = 8'h60; tick(); clr(); tick();

    tag = "R9";
    call_push_data = 16'hCAFE; call_push_req = 1; tick(); clr();
    push_req = 1; push_data = 8'h99; pop_req = 1; tick(); clr();
    ret_pop_req = 1; tick(); clr();
    pop_req = 1; tick(); clr(); tick(); tick();

    tag = "R10";
    call_push_data = 16'h5AA5; call_push_req = 1; push_req = 1; push_data = 8'h77;
    pop_req = 1; ret_pop_req = 1; tick(); clr(); tick();
    push_req = 1; push_data = 8'h66; pop_req = 1; ret_pop_req = 1; tick(); clr();
    ret_pop_req = 1; pop_req = 1; tick(); clr(); tick(); tick(); tick();

    tag = "R4";
    sp_load = 1; sp_load_data = 8'h30; tick(); clr();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      push_data = 8'($urandom);
      call_push_data = 16'($urandom);
      sp_load_data = 8'($urandom);
      push_req = (r < 30);
      call_push_req = (r >= 30 && r < 40);
      pop_req = (r >= 40 && r < 70);
      ret_pop_req = (r >= 70 && r < 80);
      sp_load = (r == 99);
      tick();
    end
    clr(); tick(); tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule